// File: doc/BRIEF.md
# Interrupt Entry and Standby Sequencer

This block controls exceptions and standby for a small 8-bit accumulator CPU. At each instruction boundary it looks at the maskable hardware request lines, the software-interrupt strobe, the return strobe and the standby strobe, and then decides what the CPU does next. When it takes an exception, it writes a five-byte frame through a stack-write port, one byte per cycle, and moves a down-counting stack pointer. It then sets the interrupt mask and requests a two-cycle vector fetch. The high index register is never part of the frame.

A return reverses the frame. The sequencer reads five bytes through a stack-read port and presents the restored registers. If an unmasked request is waiting once the frame has been restored, the sequencer starts a new entry at once, before the next instruction runs. In standby the sequencer drops the CPU clock enable and clears the mask. An interrupt or a reset ends standby. A reset input can arrive at any cycle, and it overrides every other activity.

Top module: `irq_seq`

## Requirements
- R1: When `instr_done` is high, `i_mask` is 0 and any `irq_req` line is set, the block writes 5 bytes on consecutive cycles, starting in the cycle after the boundary. The order is return-PC low byte, return-PC high byte, `x_in`, `a_in`, CCR. Each write goes to `sp`, and `sp` then decrements. The return PC is `pc_in - 1`. The stacked CCR is `ccr_in` with bit 3 replaced by the mask value held before entry.
- R2: `swi_stb` at a boundary starts an entry even when `i_mask` is 1. The entry stacks `pc_in` unchanged and uses vector `VEC_TOP - 2` (0xFFFC). It takes precedence over hardware requests at the same boundary.
- R3: Among simultaneous hardware requests, line i with the lowest index wins and uses vector `VEC_TOP - 4 - 2*i`. Requests are ignored while `i_mask` is 1 and away from an `instr_done` boundary.
- R4: After the fifth write, `i_mask` is 1 and `vec_req` is high for two cycles, with `vec_addr` equal to the vector and then the vector plus 1. After that the block is idle again.
- R5: `busy` is high from the first stack write through the last vector-fetch cycle and during every stack read. It is low while idle and in standby.
- R6: While `rst_n` is low, or in the cycle after `rst_req` is high, the block shows `sp = SP_INIT`, `i_mask = 1`, no write, and `vec_req` with `vec_addr = VEC_TOP`. `rst_req` aborts a stacking sequence that is in progress.
- R7: `halt_stb` at a boundary drives `cpu_clk_en` to 0 and `i_mask` to 0 from the next cycle on, and it holds them there while no request is present. Any request then raises `cpu_clk_en` in the next cycle, in which the entry's first write (return PC `pc_in - 1`) also takes place.
- R8: `rti_stb` at a boundary starts 5 reads on consecutive cycles. Each read first increments `sp` and then reads at the new value. The order is CCR, A, X, PC high, PC low. In the cycle after the last read, `rti_done` is high, `pc_out`/`x_out`/`a_out`/`ccr_out` hold the pulled values, and `i_mask` equals bit 3 of the pulled CCR.
- R9: If a request is present and the pulled CCR bit 3 is 0 at the end of a return, `flush` is high together with `rti_done`. In that same cycle a new entry begins that stacks the restored PC unchanged.
- R10: `cli_stb` at a boundary clears `i_mask` for later boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_req | input | 1 | Synchronous reset from any other reset source |
| irq_req | input | N_IRQ | Hardware interrupt request lines |
| instr_done | input | 1 | Instruction boundary strobe |
| swi_stb | input | 1 | Software-interrupt instruction completed |
| rti_stb | input | 1 | Return-from-interrupt instruction completed |
| halt_stb | input | 1 | Wait or stop instruction completed |
| cli_stb | input | 1 | Clear-mask instruction completed |
| pc_in | input | AW | Program counter past the prefetched opcode |
| x_in | input | 8 | Index low register |
| a_in | input | 8 | Accumulator |
| ccr_in | input | 8 | Condition codes; bit 3 is replaced by the mask |
| rd_data | input | 8 | Stack read data, same cycle as rd_addr |
| wr_en | output | 1 | Stack write strobe |
| wr_addr | output | AW | Stack write address |
| wr_data | output | 8 | Stack write byte |
| rd_en | output | 1 | Stack read strobe |
| rd_addr | output | AW | Stack read address |
| sp | output | AW | Stack pointer |
| i_mask | output | 1 | Interrupt mask |
| busy | output | 1 | Sequence in progress |
| vec_req | output | 1 | Vector fetch request |
| vec_addr | output | AW | Vector byte address |
| cpu_clk_en | output | 1 | CPU clock enable |
| rti_done | output | 1 | Return completed, restored values valid |
| flush | output | 1 | Discard the opcode prefetched by the return |
| pc_out | output | AW | Restored program counter |
| x_out | output | 8 | Restored index low |
| a_out | output | 8 | Restored accumulator |
| ccr_out | output | 8 | Restored condition codes |

## Verification
A decision made at a boundary edge shows up one cycle later. The first stack write, the first stack read, the standby clock drop and the reset vector all appear in the cycle after their strobe. Each further write or read follows one cycle after the previous one. The vector fetch fills the two cycles after the fifth write, and `rti_done`/`flush` appear in the cycle after the fifth read, overlapping the first write of a chained entry. Every stimulus is applied at a falling edge, and the bench samples the outputs at the next falling edge, one falling edge per expected cycle. It never samples anywhere else.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int N_IRQ = 4,
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = 'h00FF,
  parameter logic [AW-1:0] VEC_TOP = 'hFFFE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_req,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             instr_done,
  input  logic             swi_stb,
  input  logic             rti_stb,
  input  logic             halt_stb,
  input  logic             cli_stb,
  input  logic [AW-1:0]    pc_in,
  input  logic [7:0]       x_in,
  input  logic [7:0]       a_in,
  input  logic [7:0]       ccr_in,
  input  logic [7:0]       rd_data,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic [AW-1:0]    sp,
  output logic             i_mask,
  output logic             busy,
  output logic             vec_req,
  output logic [AW-1:0]    vec_addr,
  output logic             cpu_clk_en,
  output logic             rti_done,
  output logic             flush,
  output logic [AW-1:0]    pc_out,
  output logic [7:0]       x_out,
  output logic [7:0]       a_out,
  output logic [7:0]       ccr_out
);
  localparam int IW = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam logic [AW-1:0] V_SWI = VEC_TOP - AW'(2);
  localparam logic [AW-1:0] V_HW0 = VEC_TOP - AW'(4);

  typedef enum logic [2:0] {S_RUN, S_PUSH, S_VEC, S_SLEEP, S_PULL} st_t;

  st_t           st;
  logic [2:0]    cnt;
  logic          vph;
  logic [AW-1:0] sp_q, vbase, ret_q;
  logic [7:0]    x_q, a_q, c_q;
  logic          imask;
  logic [IW-1:0] win;
  logic [AW-1:0] hw_vec;
  logic          any_req;

  always_comb begin
    win = '0;
    for (int i = N_IRQ - 1; i >= 0; i--)
      if (irq_req[i]) win = IW'(i);
  end

  assign any_req = |irq_req;
  assign hw_vec  = V_HW0 - (AW'(win) << 1);

  assign wr_en      = (st == S_PUSH);
  assign wr_addr    = sp_q;
  assign rd_en      = (st == S_PULL);
  assign rd_addr    = sp_q + AW'(1);
  assign sp         = sp_q;
  assign i_mask     = imask;
  assign busy       = (st == S_PUSH) || (st == S_VEC) || (st == S_PULL);
  assign vec_req    = (st == S_VEC);
  assign vec_addr   = vbase + AW'(vph);
  assign cpu_clk_en = (st != S_SLEEP);
  assign pc_out     = ret_q;
  assign x_out      = x_q;
  assign a_out      = a_q;
  assign ccr_out    = c_q;

  always_comb begin
    case (cnt)
      3'd0:    wr_data = ret_q[7:0];
      3'd1:    wr_data = 8'(ret_q >> 8);
      3'd2:    wr_data = x_q;
      3'd3:    wr_data = a_q;
      default: wr_data = c_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_VEC;
      cnt      <= '0;
      vph      <= 1'b0;
      vbase    <= VEC_TOP;
      sp_q     <= SP_INIT;
      imask    <= 1'b1;
      ret_q    <= '0;
      x_q      <= '0;
      a_q      <= '0;
      c_q      <= '0;
      rti_done <= 1'b0;
      flush    <= 1'b0;
    end else begin
      rti_done <= 1'b0;
      flush    <= 1'b0;
      if (rst_req) begin
        st    <= S_VEC;
        cnt   <= '0;
        vph   <= 1'b0;
        vbase <= VEC_TOP;
        sp_q  <= SP_INIT;
        imask <= 1'b1;
      end else begin
        case (st)
          S_RUN: if (instr_done) begin
            if (cli_stb) imask <= 1'b0;
            if (swi_stb || rti_stb || halt_stb || (any_req && !imask)) begin
              x_q <= x_in;
              a_q <= a_in;
              c_q <= {ccr_in[7:4], imask, ccr_in[2:0]};
              cnt <= '0;
            end
            if (swi_stb) begin
              st    <= S_PUSH;
              ret_q <= pc_in;
              vbase <= V_SWI;
            end else if (rti_stb) begin
              st <= S_PULL;
            end else if (halt_stb) begin
              st    <= S_SLEEP;
              imask <= 1'b0;
            end else if (any_req && !imask) begin
              st    <= S_PUSH;
              ret_q <= pc_in - AW'(1);
              vbase <= hw_vec;
            end
          end
          S_SLEEP: if (any_req) begin
            st    <= S_PUSH;
            cnt   <= '0;
            ret_q <= pc_in - AW'(1);
            x_q   <= x_in;
            a_q   <= a_in;
            c_q   <= {ccr_in[7:4], imask, ccr_in[2:0]};
            vbase <= hw_vec;
          end
          S_PUSH: begin
            sp_q <= sp_q - AW'(1);
            cnt  <= cnt + 3'd1;
            if (cnt == 3'd4) begin
              st    <= S_VEC;
              vph   <= 1'b0;
              imask <= 1'b1;
            end
          end
          S_VEC: begin
            vph <= ~vph;
            if (vph) st <= S_RUN;
          end
          S_PULL: begin
            sp_q <= sp_q + AW'(1);
            cnt  <= cnt + 3'd1;
            case (cnt)
              3'd0: c_q   <= rd_data;
              3'd1: a_q   <= rd_data;
              3'd2: x_q   <= rd_data;
              3'd3: ret_q <= AW'({rd_data, 8'h00});
              default: begin
                ret_q    <= ret_q | AW'(rd_data);
                imask    <= c_q[3];
                rti_done <= 1'b1;
                cnt      <= '0;
                if (any_req && !c_q[3]) begin
                  st    <= S_PUSH;
                  flush <= 1'b1;
                  vbase <= hw_vec;
                end else begin
                  st <= S_RUN;
                end
              end
            endcase
          end
          default: st <= S_RUN;
        endcase
      end
    end
  end
endmodule

module irq_seq_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = 'h00FF,
  parameter logic [AW-1:0] VEC_TOP = 'hFFFE
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] sp,
  input logic          i_mask,
  input logic          busy,
  input logic          vec_req,
  input logic [AW-1:0] vec_addr,
  input logic          cpu_clk_en,
  input logic          rti_done,
  input logic          flush
);
  a_r1_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rst_req) |=> sp == $past(sp) - AW'(1));

  a_r8_pull_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rst_req) |=> sp == $past(sp) + AW'(1));

  a_r4_vec_follows_push: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_req) && !$past(rst_req)) |-> (i_mask && $past(wr_en)));

  a_r6_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (vec_req && vec_addr == VEC_TOP && i_mask && sp == SP_INIT && !wr_en));

  a_r7_sleep_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_clk_en) |-> !i_mask);

  a_r5_idle_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_clk_en |-> !busy);

  a_r9_flush_starts_entry: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (wr_en && rti_done));
endmodule

bind irq_seq irq_seq_chk #(.AW(AW), .SP_INIT(SP_INIT), .VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .wr_en(wr_en), .rd_en(rd_en),
  .sp(sp), .i_mask(i_mask), .busy(busy), .vec_req(vec_req), .vec_addr(vec_addr),
  .cpu_clk_en(cpu_clk_en), .rti_done(rti_done), .flush(flush)
);

// File: tb/irq_seq_tb.sv
`timescale 1ns/1ps
module irq_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n, rst_req, instr_done, swi_stb, rti_stb, halt_stb, cli_stb;
  logic [3:0]  irq_req;
  logic [15:0] pc_in;
  logic [7:0]  x_in, a_in, ccr_in, rd_data;
  logic        wr_en, rd_en, i_mask, busy, vec_req, cpu_clk_en, rti_done, flush;
  logic [15:0] wr_addr, rd_addr, sp, vec_addr, pc_out;
  logic [7:0]  wr_data, x_out, a_out, ccr_out;
  logic [7:0]  mem [0:255];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq_req(irq_req),
    .instr_done(instr_done), .swi_stb(swi_stb), .rti_stb(rti_stb),
    .halt_stb(halt_stb), .cli_stb(cli_stb), .pc_in(pc_in), .x_in(x_in),
    .a_in(a_in), .ccr_in(ccr_in), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .sp(sp), .i_mask(i_mask), .busy(busy), .vec_req(vec_req),
    .vec_addr(vec_addr), .cpu_clk_en(cpu_clk_en), .rti_done(rti_done),
    .flush(flush), .pc_out(pc_out), .x_out(x_out), .a_out(a_out),
    .ccr_out(ccr_out)
  );

  always @(posedge clk) if (wr_en) mem[wr_addr[7:0]] <= wr_data;
  assign rd_data = mem[rd_addr[7:0]];

  // fields: irq[22:19] swi[18] cli[17] take[16] vector[15:0]
  localparam logic [22:0] TBL [8] = '{
    {4'b0001, 1'b0, 1'b1, 1'b1, 16'hFFFA},
    {4'b0110, 1'b0, 1'b1, 1'b1, 16'hFFF8},
    {4'b1000, 1'b0, 1'b1, 1'b1, 16'hFFF4},
    {4'b1100, 1'b0, 1'b1, 1'b1, 16'hFFF6},
    {4'b0001, 1'b0, 1'b0, 1'b0, 16'h0000},
    {4'b0000, 1'b1, 1'b0, 1'b1, 16'hFFFC},
    {4'b0011, 1'b1, 1'b1, 1'b1, 16'hFFFC},
    {4'b0000, 1'b0, 1'b1, 1'b0, 16'h0000}
  };

  task automatic step;
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bnd(input logic swi, input logic rti, input logic halt, input logic cli);
    instr_done = 1'b1; swi_stb = swi; rti_stb = rti; halt_stb = halt; cli_stb = cli;
    step;
    instr_done = 1'b0; swi_stb = 1'b0; rti_stb = 1'b0; halt_stb = 1'b0; cli_stb = 1'b0;
  endtask

  task automatic do_reset_req;
    irq_req = '0;
    rst_req = 1'b1;
    step;
    rst_req = 1'b0;
    step;
    step;
  endtask

  task automatic expect_entry(input string req, input logic [15:0] ret, input logic [7:0] x,
                              input logic [7:0] a, input logic [7:0] c,
                              input logic [15:0] vec, input logic [15:0] sp0);
    logic [7:0] exp_b [5];
    exp_b[0] = ret[7:0]; exp_b[1] = ret[15:8]; exp_b[2] = x; exp_b[3] = a; exp_b[4] = c;
    for (int k = 0; k < 5; k++) begin
      chk(req, "wr_en", wr_en, 1);
      chk(req, "wr_addr", wr_addr, sp0 - 16'(k));
      chk(req, "wr_data", wr_data, exp_b[k]);
      chk("R5", "busy in push", busy, 1);
      step;
    end
    chk("R4", "vec_req 1st", vec_req, 1);
    chk("R4", "vec_addr 1st", vec_addr, vec);
    chk("R4", "mask set", i_mask, 1);
    chk("R5", "busy in vec", busy, 1);
    chk("R1", "sp after push", sp, sp0 - 16'd5);
    step;
    chk("R4", "vec_req 2nd", vec_req, 1);
    chk("R4", "vec_addr 2nd", vec_addr, vec + 16'd1);
    step;
    chk("R4", "vec done", vec_req, 0);
    chk("R5", "busy idle", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; rst_req = 1'b0; instr_done = 1'b0; swi_stb = 1'b0; rti_stb = 1'b0;
    halt_stb = 1'b0; cli_stb = 1'b0; irq_req = '0; pc_in = 16'h0100;
    x_in = 8'h11; a_in = 8'h22; ccr_in = 8'hC1;
    repeat (3) step;
    rst_n = 1'b1;
    chk("R6", "reset sp", sp, 16'h00FF);
    chk("R6", "reset mask", i_mask, 1);
    chk("R6", "reset vec_req", vec_req, 1);
    chk("R6", "reset vec_addr", vec_addr, 16'hFFFE);
    chk("R6", "reset wr_en", wr_en, 0);
    chk("R7", "reset clk_en", cpu_clk_en, 1);
    step;
    step;
    chk("R5", "idle after reset", busy, 0);

    // R1 R2 R3 R10 table walk
    for (int i = 0; i < 8; i++) begin
      logic [3:0]  t_irq  = TBL[i][22:19];
      logic        t_swi  = TBL[i][18];
      logic        t_cli  = TBL[i][17];
      logic        t_take = TBL[i][16];
      logic [15:0] t_vec  = TBL[i][15:0];
      logic [15:0] pc     = 16'h1230 + 16'(i * 16);
      pc_in = pc; x_in = 8'h10 + 8'(i); a_in = 8'h20 + 8'(i); ccr_in = 8'hC1;
      if (t_cli) begin
        bnd(0, 0, 0, 1);
        chk("R10", "mask cleared", i_mask, 0);
      end
      irq_req = t_irq;
      step;
      chk("R3", "no take off boundary", wr_en, 0);
      bnd(t_swi, 0, 0, 0);
      if (t_take)
        expect_entry(t_swi ? "R2" : "R1", t_swi ? pc : pc - 16'd1, 8'h10 + 8'(i), 8'h20 + 8'(i),
                     t_cli ? 8'hC1 : 8'hC9, t_vec, 16'h00FF);
      else begin
        chk("R3", "masked/no request", wr_en, 0);
        chk("R3", "masked busy", busy, 0);
      end
      do_reset_req();
    end

    // R6 abort mid-stack
    bnd(0, 0, 0, 1);
    irq_req = 4'b0001;
    bnd(0, 0, 0, 0);
    chk("R1", "entry begins", wr_en, 1);
    step;
    rst_req = 1'b1;
    irq_req = '0;
    step;
    rst_req = 1'b0;
    chk("R6", "abort no write", wr_en, 0);
    chk("R6", "abort vec_req", vec_req, 1);
    chk("R6", "abort vec_addr", vec_addr, 16'hFFFE);
    chk("R6", "abort sp", sp, 16'h00FF);
    chk("R6", "abort mask", i_mask, 1);
    step;
    step;

    // R7 standby and wake
    pc_in = 16'h4000; x_in = 8'h3C; a_in = 8'h4D; ccr_in = 8'hC1;
    bnd(0, 0, 1, 0);
    chk("R7", "clk_en low", cpu_clk_en, 0);
    chk("R7", "mask cleared", i_mask, 0);
    chk("R5", "busy low in sleep", busy, 0);
    repeat (3) step;
    chk("R7", "still asleep", cpu_clk_en, 0);
    irq_req = 4'b1000;
    step;
    chk("R7", "woken", cpu_clk_en, 1);
    expect_entry("R7", 16'h3FFF, 8'h3C, 8'h4D, 8'hC1, 16'hFFF4, 16'h00FF);
    irq_req = '0;

    // R8 return without pending request
    x_in = 8'h00; a_in = 8'h00;
    bnd(0, 1, 0, 0);
    for (int k = 0; k < 5; k++) begin
      chk("R8", "rd_en", rd_en, 1);
      chk("R8", "rd_addr", rd_addr, 16'h00FB + 16'(k));
      chk("R5", "busy in pull", busy, 1);
      step;
    end
    chk("R8", "rti_done", rti_done, 1);
    chk("R9", "no flush", flush, 0);
    chk("R8", "pc_out", pc_out, 16'h3FFF);
    chk("R8", "x_out", x_out, 8'h3C);
    chk("R8", "a_out", a_out, 8'h4D);
    chk("R8", "ccr_out", ccr_out, 8'hC1);
    chk("R8", "mask restored", i_mask, 0);
    chk("R8", "sp restored", sp, 16'h00FF);
    chk("R8", "no write", wr_en, 0);

    // R9 pending request taken right after return
    pc_in = 16'h5000; x_in = 8'h66; a_in = 8'h77; ccr_in = 8'hC1;
    irq_req = 4'b0010;
    bnd(0, 0, 0, 0);
    expect_entry("R1", 16'h4FFF, 8'h66, 8'h77, 8'hC1, 16'hFFF8, 16'h00FF);
    irq_req = 4'b0001;
    pc_in = 16'h6000;
    bnd(0, 1, 0, 0);
    repeat (5) step;
    chk("R9", "rti_done", rti_done, 1);
    chk("R9", "flush", flush, 1);
    expect_entry("R9", 16'h4FFF, 8'h66, 8'h77, 8'hC1, 16'hFFFA, 16'h00FF);
    irq_req = '0;
    step;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule